// File: doc/BRIEF.md
# Sub-Sampling Phase-Path Loop Filter

This block is the digital filter in the phase-locking path of a sub-sampling all-digital PLL. On every reference clock edge it takes an unsigned 4-bit code from a flash-ADC phase detector. That code is the oscillator's differential voltage sampled at the reference edge. Mid-scale means the oscillator zero crossing lines up with the reference edge. The block turns this code into a signed error and passes it through a proportional-plus-integral filter whose gains are set by shifts. The filter output goes to one of two tuning codes for an LC oscillator.

During acquisition the filter drives a 7-bit code for the medium capacitor bank, and the 6-bit tracking code rests at mid-scale. When acquisition ends, the medium code is frozen and the filter drives the tracking code instead. A third-order MASH 1-1-1 modulator dithers the tracking code onto three fine-tuning bits. The coarse frequency loop gives control to this block through an enable. All logic runs on the reference clock.

Top module: `phase_path_filter`

## Requirements
- R1: When reset is asserted (asynchronous, active low), the acquisition code goes to 64 and the tracking code to 32. The fine bits go to 3, and the integrator and all modulator state are cleared to zero.
- R2: The signed error is the phase code minus 8. Code 8 is zero error, and a run of code-8 samples in one mode leaves the active output code unchanged.
- R3: On each enabled edge, the integrator adds the error. The active code becomes mid-scale + (error << KP_SHIFT) + (integrator >>> KI_SHIFT), using the integrator value after this edge's update. The new code is visible one clock after the sample. The defaults are KP_SHIFT=1 and KI_SHIFT=3.
- R4: The integrator saturates at -512 and +511 (INT_W=10) and never wraps. After a long run at code 15 followed by one code-0 sample, the acquisition code reads 110. After a long run at code 0 followed by one code-15 sample in tracking, the tracking code reads 0.
- R5: The acquisition code is clamped to 0..127 and the tracking code to 0..63.
- R6: While acqMode is high and the loop is enabled, the acquisition code updates and the tracking code is held at 32.
- R7: While acqMode is low and the loop is enabled, the acquisition code holds its value and only the tracking code updates.
- R8: On the first enabled edge after acqMode differs from its value at the previous enabled edge, the integrator restarts from zero before the current error is added.
- R9: While loopEn is low, both codes and the integrator hold their values whatever the phase code.
- R10: The fine bits equal y + 3, where y = c1 + (c2 - c2') + (c3 - 2c3' + c3''). Here c1..c3 are the carries of three cascaded 6-bit accumulators fed by the tracking code, and primes mark earlier cycles. Over 64 cycles of a constant tracking code x, the sum of y lies within x±3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loopEn | input | 1 | Phase loop enabled by the frequency-locked loop |
| acqMode | input | 1 | High: acquisition segment active; low: tracking segment active |
| phaseCode | input | 4 | Flash-ADC phase code, mid-scale 8 at lock |
| acqCode | output | 7 | Medium-bank acquisition code |
| trkCode | output | 6 | Tracking code |
| fineBits | output | 3 | Dithered fine-tuning bits |

## Verification
Two things can happen on the same edge: a mode handover that restarts the integrator, and a fresh nonzero error sample that must still be applied. The bench drives the acqMode change together with codes 13 and 8. It then checks that the newly active code holds exactly the proportional part plus the restarted integral, and that the other code is frozen or parked at mid-scale. Integrator saturation combined with output clamping is judged the same way: one sample of the opposite sign is applied just after a saturating run, and the output is checked.

// File: rtl/ppf_pkg.sv
`timescale 1ns/1ps
package ppf_pkg;
  typedef struct packed {
    logic intEn;
    logic clrInteg;
    logic updAcq;
    logic updTrk;
  } ppfStrobe_t;
endpackage

// File: rtl/ppf_ctrl.sv
`timescale 1ns/1ps
module ppf_ctrl
  import ppf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loopEn,
  input  logic       acqMode,
  output ppfStrobe_t strobe
);
  logic lastMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       lastMode <= 1'b1;
    else if (loopEn) lastMode <= acqMode;
  end

  always_comb begin
    strobe.intEn    = loopEn;
    strobe.clrInteg = loopEn && (acqMode != lastMode);
    strobe.updAcq   = loopEn && acqMode;
    strobe.updTrk   = loopEn && !acqMode;
  end
endmodule

// File: rtl/ppf_datapath.sv
`timescale 1ns/1ps
module ppf_datapath
  import ppf_pkg::*;
#(
  parameter int ERR_W    = 4,
  parameter int ACQ_W    = 7,
  parameter int TRK_W    = 6,
  parameter int INT_W    = 10,
  parameter int KP_SHIFT = 1,
  parameter int KI_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ppfStrobe_t       strobe,
  input  logic [ERR_W-1:0] phaseCode,
  output logic [ACQ_W-1:0] acqCode,
  output logic [TRK_W-1:0] trkCode
);
  localparam int CW      = INT_W + ERR_W + KP_SHIFT + 2;
  localparam int ERR_MID = 2 ** (ERR_W - 1);
  localparam logic signed [CW-1:0] INT_HI  = CW'((2 ** (INT_W - 1)) - 1);
  localparam logic signed [CW-1:0] INT_LO  = CW'(-(2 ** (INT_W - 1)));
  localparam logic signed [CW-1:0] ACQ_HI  = CW'((2 ** ACQ_W) - 1);
  localparam logic signed [CW-1:0] ACQ_MID = CW'(2 ** (ACQ_W - 1));
  localparam logic signed [CW-1:0] TRK_HI  = CW'((2 ** TRK_W) - 1);
  localparam logic signed [CW-1:0] TRK_MID = CW'(2 ** (TRK_W - 1));
  localparam logic signed [CW-1:0] ZERO    = '0;

  function automatic logic signed [CW-1:0] clampTo(
    input logic signed [CW-1:0] v,
    input logic signed [CW-1:0] lo,
    input logic signed [CW-1:0] hi
  );
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  logic signed [INT_W-1:0] integ;
  logic signed [ERR_W:0]   errS;
  logic signed [CW-1:0]    errW, integBase, integSum, integNext;
  logic signed [CW-1:0]    pTerm, iTerm, ctrlVal;

  always_comb begin
    errS      = $signed({1'b0, phaseCode}) - $signed((ERR_W + 1)'(ERR_MID));
    errW      = CW'(errS);
    integBase = strobe.clrInteg ? ZERO : CW'(integ);
    integSum  = integBase + errW;
    integNext = clampTo(integSum, INT_LO, INT_HI);
    pTerm     = errW <<< KP_SHIFT;
    iTerm     = integNext >>> KI_SHIFT;
    ctrlVal   = pTerm + iTerm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      integ   <= '0;
      acqCode <= ACQ_W'(ACQ_MID);
      trkCode <= TRK_W'(TRK_MID);
    end else if (strobe.intEn) begin
      integ <= INT_W'(integNext);
      if (strobe.updAcq) begin
        acqCode <= ACQ_W'(clampTo(ACQ_MID + ctrlVal, ZERO, ACQ_HI));
        trkCode <= TRK_W'(TRK_MID);
      end
      if (strobe.updTrk) begin
        trkCode <= TRK_W'(clampTo(TRK_MID + ctrlVal, ZERO, TRK_HI));
      end
    end
  end
endmodule

// File: rtl/ppf_mash.sv
`timescale 1ns/1ps
module ppf_mash #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] codeIn,
  output logic [2:0]   fineBits
);
  logic [W-1:0] acc1, acc2, acc3;
  logic [W:0]   sum1, sum2, sum3;
  logic         carry2Prev, carry3Prev, carry3Prev2;
  logic signed [3:0] yVal, fineWide;

  always_comb begin
    sum1 = {1'b0, acc1} + {1'b0, codeIn};
    sum2 = {1'b0, acc2} + {1'b0, sum1[W-1:0]};
    sum3 = {1'b0, acc3} + {1'b0, sum2[W-1:0]};
    yVal = $signed({3'b000, sum1[W]})
         + $signed({3'b000, sum2[W]}) - $signed({3'b000, carry2Prev})
         + $signed({3'b000, sum3[W]}) - $signed({2'b00, carry3Prev, 1'b0})
         + $signed({3'b000, carry3Prev2});
    fineWide = yVal + 4'sd3;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc1        <= '0;
      acc2        <= '0;
      acc3        <= '0;
      carry2Prev  <= 1'b0;
      carry3Prev  <= 1'b0;
      carry3Prev2 <= 1'b0;
      fineBits    <= 3'd3;
    end else begin
      acc1        <= sum1[W-1:0];
      acc2        <= sum2[W-1:0];
      acc3        <= sum3[W-1:0];
      carry2Prev  <= sum2[W];
      carry3Prev  <= sum3[W];
      carry3Prev2 <= carry3Prev;
      fineBits    <= fineWide[2:0];
    end
  end
endmodule

// File: rtl/phase_path_filter.sv
`timescale 1ns/1ps
module phase_path_filter
  import ppf_pkg::*;
#(
  parameter int ERR_W    = 4,
  parameter int ACQ_W    = 7,
  parameter int TRK_W    = 6,
  parameter int INT_W    = 10,
  parameter int KP_SHIFT = 1,
  parameter int KI_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loopEn,
  input  logic             acqMode,
  input  logic [ERR_W-1:0] phaseCode,
  output logic [ACQ_W-1:0] acqCode,
  output logic [TRK_W-1:0] trkCode,
  output logic [2:0]       fineBits
);
  ppfStrobe_t strobe;

  ppf_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loopEn  (loopEn),
    .acqMode (acqMode),
    .strobe  (strobe)
  );

  ppf_datapath #(
    .ERR_W    (ERR_W),
    .ACQ_W    (ACQ_W),
    .TRK_W    (TRK_W),
    .INT_W    (INT_W),
    .KP_SHIFT (KP_SHIFT),
    .KI_SHIFT (KI_SHIFT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .phaseCode (phaseCode),
    .acqCode   (acqCode),
    .trkCode   (trkCode)
  );

  ppf_mash #(.W(TRK_W)) u_mash (
    .clk      (clk),
    .rstN     (rstN),
    .codeIn   (trkCode),
    .fineBits (fineBits)
  );
endmodule

// File: rtl/ppf_checker.sv
`timescale 1ns/1ps
module ppf_checker #(
  parameter int ERR_W = 4,
  parameter int ACQ_W = 7,
  parameter int TRK_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             loopEn,
  input logic             acqMode,
  input logic [ERR_W-1:0] phaseCode,
  input logic [ACQ_W-1:0] acqCode,
  input logic [TRK_W-1:0] trkCode
);
  localparam logic [ERR_W-1:0] ERR_ZERO = ERR_W'(2 ** (ERR_W - 1));
  localparam logic [TRK_W-1:0] TRK_MID  = TRK_W'(2 ** (TRK_W - 1));

  a_r6_trk_parked: assert property (@(posedge clk) disable iff (!rstN)
    (loopEn && acqMode) |=> (trkCode == TRK_MID));

  a_r7_acq_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (loopEn && !acqMode) |=> $stable(acqCode));

  a_r9_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    (!loopEn) |=> ($stable(acqCode) && $stable(trkCode)));

  a_r2_zero_err_trk: assert property (@(posedge clk) disable iff (!rstN)
    (loopEn && !acqMode && phaseCode == ERR_ZERO) ##1
    (loopEn && !acqMode && phaseCode == ERR_ZERO) |=> $stable(trkCode));

  a_r2_zero_err_acq: assert property (@(posedge clk) disable iff (!rstN)
    (loopEn && acqMode && phaseCode == ERR_ZERO) ##1
    (loopEn && acqMode && phaseCode == ERR_ZERO) |=> $stable(acqCode));
endmodule

bind phase_path_filter ppf_checker #(
  .ERR_W (ERR_W),
  .ACQ_W (ACQ_W),
  .TRK_W (TRK_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .loopEn    (loopEn),
  .acqMode   (acqMode),
  .phaseCode (phaseCode),
  .acqCode   (acqCode),
  .trkCode   (trkCode)
);

// File: tb/phase_path_filter_tb.sv
`timescale 1ns/1ps
module phase_path_filter_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic       loopEn;
  logic       acqMode;
  logic [3:0] phaseCode;
  logic [6:0] acqCode;
  logic [5:0] trkCode;
  logic [2:0] fineBits;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  phase_path_filter u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .loopEn    (loopEn),
    .acqMode   (acqMode),
    .phaseCode (phaseCode),
    .acqCode   (acqCode),
    .trkCode   (trkCode),
    .fineBits  (fineBits)
  );

  // {loopEn, acqMode, phaseCode, expected acqCode, expected trkCode}
  localparam int NVEC = 11;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 4'd12, 7'd72, 6'd32},
    {1'b1, 1'b1, 4'd15, 7'd79, 6'd32},
    {1'b1, 1'b1, 4'd0,  7'd48, 6'd32},
    {1'b0, 1'b1, 4'd15, 7'd48, 6'd32},
    {1'b1, 1'b1, 4'd8,  7'd64, 6'd32},
    {1'b1, 1'b1, 4'd3,  7'd53, 6'd32},
    {1'b1, 1'b0, 4'd13, 7'd53, 6'd42},
    {1'b1, 1'b0, 4'd13, 7'd53, 6'd43},
    {1'b1, 1'b0, 4'd8,  7'd53, 6'd33},
    {1'b1, 1'b0, 4'd1,  7'd53, 6'd18},
    {1'b1, 1'b1, 4'd8,  7'd64, 6'd32}
  };

  function automatic string vecTag(input int i);
    case (i)
      0, 1, 2: return "R3 R6 acquisition update";
      3:       return "R9 disabled hold";
      4:       return "R2 zero error";
      5:       return "R3 negative integral";
      6:       return "R8 R7 handover with error";
      7:       return "R3 R7 tracking";
      8:       return "R2 R7 zero error tracking";
      9:       return "R7 negative tracking";
      default: return "R8 R6 return to acquisition";
    endcase
  endfunction

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkNear(input string tag, input int act, input int exp, input int tol);
    checks++;
    if (act < exp - tol || act > exp + tol) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d+-%0d", tag, act, exp, tol);
    end
  endtask

  task automatic step(input logic en, input logic md, input logic [3:0] pc);
    loopEn    = en;
    acqMode   = md;
    phaseCode = pc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sumFine(input int n, output int s);
    s = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      s += int'(fineBits) - 3;
    end
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1..all: actual hung expected finish");
      finishRun();
    end
  end

  initial begin
    int s;
    rstN = 1'b0; loopEn = 1'b0; acqMode = 1'b1; phaseCode = 4'd8;
    repeat (3) @(negedge clk);
    checkEq("R1 reset acqCode", int'(acqCode), 64);
    checkEq("R1 reset trkCode", int'(trkCode), 32);
    checkEq("R1 reset fineBits", int'(fineBits), 3);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][18], VEC[i][17], VEC[i][16:13]);
      checkEq(vecTag(i), int'(acqCode), int'(VEC[i][12:6]));
      checkEq(vecTag(i), int'(trkCode), int'(VEC[i][5:0]));
    end

    // positive saturation in acquisition
    repeat (100) step(1'b1, 1'b1, 4'd15);
    checkEq("R5 acq clamp high", int'(acqCode), 127);
    step(1'b1, 1'b1, 4'd0);
    checkEq("R4 integ no wrap high", int'(acqCode), 110);

    // negative saturation in tracking
    repeat (100) step(1'b1, 1'b0, 4'd0);
    checkEq("R5 trk clamp low", int'(trkCode), 0);
    checkEq("R7 acq frozen", int'(acqCode), 110);
    step(1'b1, 1'b0, 4'd15);
    checkEq("R4 integ no wrap low", int'(trkCode), 0);

    repeat (3) step(1'b1, 1'b0, 4'd8);
    sumFine(64, s);
    checkNear("R10 mash mean x=0", s, 0, 3);

    step(1'b1, 1'b1, 4'd8);
    checkEq("R8 clear on mode change", int'(acqCode), 64);
    checkEq("R6 trk parked", int'(trkCode), 32);
    repeat (2) step(1'b1, 1'b1, 4'd8);
    sumFine(64, s);
    checkNear("R10 mash mean x=32", s, 32, 3);

    repeat (100) step(1'b1, 1'b0, 4'd15);
    checkEq("R5 trk clamp high", int'(trkCode), 63);
    sumFine(64, s);
    checkNear("R10 mash mean x=63", s, 63, 3);

    step(1'b0, 1'b0, 4'd0);
    checkEq("R9 hold in tracking", int'(trkCode), 63);

    rstN = 1'b0;
    #1;
    checkEq("R1 async reset acqCode", int'(acqCode), 64);
    checkEq("R1 async reset trkCode", int'(trkCode), 32);
    checkEq("R1 async reset fineBits", int'(fineBits), 3);
    finishRun();
  end
endmodule